// File: doc/BRIEF.md
# Segment Display Refresh Sequencer

This block sits in front of a serial segment driver that has a shift register, a latch and one output per segment. It keeps an 80-bit frame image. It also produces a free-running square wave with 50% duty, which the panel drive uses to alternate polarity. When a new image arrives, the block sends all of its bits out as a shift clock plus serial data, then raises a latch pulse. The falling edge of that pulse is placed on the falling edge of the alternating signal, so the panel never sees a DC component when the image changes.

A one-cycle load strobe accepts a new image at any time. An image that arrives during a transfer is held and goes out in the next update, so a transfer never mixes two images. If a mode bit is set when the image is loaded, segment 1 is always sent as 0, and that driver channel can then serve as the common electrode. Every period is a count of system clock cycles set by a parameter.

Top module: `segment_refresh_seq`

## Requirements
- R1: The output `frm` is low after reset and toggles every FRAME_HALF cycles, so each high and each low phase lasts exactly FRAME_HALF cycles.
- R2: `lat` stays high for exactly LATCH_W cycles, and it falls on the same clock edge on which `frm` falls.
- R3: Each update sends exactly NSEG pulses on `sck`. Every high phase lasts exactly SCK_HALF cycles, and every low phase between pulses also lasts SCK_HALF cycles.
- R4: The bit for the highest-numbered segment goes first. The bit for segment k is `image[k-1]`, and segment 1 goes last. `sdat` changes only on rising edges of `sck`, so it is stable across every falling edge.
- R5: `sck` stays low while `lat` is high. The first `sck` fall after a latch fall comes at least SCK_HALF+1 cycles later.
- R6: If `com_mode` is 1 when `load` is accepted, the bit for segment 1 is sent as 0. The bits for segments 2 to NSEG still carry the image.
- R7: A `load` during a transfer does not change the bits being sent. The new image is sent complete in the next update.
- R8: `busy` rises with the first `sck` pulse and stays high until the edge on which `lat` falls. `done` is high for exactly one cycle, starting on that same edge.
- R9: During reset `frm`, `sck`, `sdat`, `lat`, `busy` and `done` are all 0.
- R10: Without a `load`, no `sck` pulse and no latch occur, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Strobe that accepts `image` and `com_mode` |
| com_mode | input | 1 | Forces the segment 1 bit to 0 for this image |
| image | input | NSEG | Frame image; bit k-1 drives segment k |
| frm | output | 1 | Alternating frame signal with 50% duty |
| sck | output | 1 | Shift clock; the driver samples data on its fall |
| sdat | output | 1 | Serial segment data |
| lat | output | 1 | Latch pulse; the driver latches on its fall |
| busy | output | 1 | An update is in progress |
| done | output | 1 | One-cycle pulse after each completed latch |

## Verification
The bench builds the block with FRAME_HALF=2000, SCK_HALF=2 and LATCH_W=3, and keeps NSEG at 80. This puts several frame periods inside a short run, and a whole 80-bit transfer takes 320 cycles, far less than a frame half period. At these values the bench can watch back-to-back updates, where a second image loaded during a transfer goes out right after the first latch. It can also measure exact pulse widths, the gap after a latch, and where the latch falls on the frame edge.

// File: rtl/seg_refresh_pkg.sv
package seg_refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_WAIT  = 2'd2,
    ST_LATCH = 2'd3
  } seq_state_t;
endpackage

// File: rtl/seg_frame_gen.sv
// Free-running alternating frame signal plus latch timing hints.
module seg_frame_gen #(
  parameter int HALF  = 833333,
  parameter int LAT_W = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic frm,
  output logic arm,
  output logic fall_now
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          frm_q, frm_d;

  always_comb begin
    cnt_d = cnt_q - CW'(1);
    frm_d = frm_q;
    if (cnt_q == '0) begin
      cnt_d = CW'(HALF - 1);
      frm_d = ~frm_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(HALF - 1);
      frm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      frm_q <= frm_d;
    end
  end

  assign frm      = frm_q;
  // Raising the latch here leaves exactly LAT_W high cycles before the fall.
  assign arm      = frm_q && (cnt_q == CW'(LAT_W));
  assign fall_now = frm_q && (cnt_q == '0);
endmodule

// File: rtl/seg_serializer.sv
// Sends N bits MSB first; data moves on sck rise, the driver samples on fall.
module seg_serializer #(
  parameter int N    = 80,
  parameter int HALF = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] word,
  output logic         sck,
  output logic         sdat,
  output logic         fin
);
  localparam int PW = $clog2(HALF + 1);
  localparam int BW = $clog2(N);

  logic          act_q, act_d;
  logic          sck_q, sck_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [N-1:0]  sh_q, sh_d;

  always_comb begin
    act_d = act_q;
    sck_d = sck_q;
    ph_d  = ph_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    fin   = 1'b0;
    if (start) begin
      act_d = 1'b1;
      sck_d = 1'b1;
      ph_d  = '0;
      bit_d = '0;
      sh_d  = word;
    end else if (act_q) begin
      if (ph_q == PW'(HALF - 1)) begin
        ph_d = '0;
        if (sck_q) begin
          sck_d = 1'b0;
        end else if (bit_q == BW'(N - 1)) begin
          act_d = 1'b0;
          fin   = 1'b1;
        end else begin
          sh_d  = {sh_q[N-2:0], 1'b0};
          bit_d = bit_q + BW'(1);
          sck_d = 1'b1;
        end
      end else begin
        ph_d = ph_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sck_q <= 1'b0;
      ph_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      act_q <= act_d;
      sck_q <= sck_d;
      ph_q  <= ph_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign sck  = sck_q;
  assign sdat = act_q & sh_q[N-1];
endmodule

// File: rtl/segment_refresh_seq.sv
module segment_refresh_seq
  import seg_refresh_pkg::*;
#(
  parameter int NSEG       = 80,
  parameter int FRAME_HALF = 833333,
  parameter int SCK_HALF   = 50,
  parameter int LATCH_W    = 50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            com_mode,
  input  logic [NSEG-1:0] image,
  output logic            frm,
  output logic            sck,
  output logic            sdat,
  output logic            lat,
  output logic            busy,
  output logic            done
);
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic arm, fall_now, fin, start;

  seg_frame_gen #(.HALF(FRAME_HALF), .LAT_W(LATCH_W)) u_frame (
    .clk(clk), .rst_n(rst_int_n), .frm(frm), .arm(arm), .fall_now(fall_now)
  );

  seq_state_t      state_q, state_d;
  logic [NSEG-1:0] pend_q, pend_d;
  logic            pend_v_q, pend_v_d;
  logic            lat_q, done_q;

  seg_serializer #(.N(NSEG), .HALF(SCK_HALF)) u_ser (
    .clk(clk), .rst_n(rst_int_n), .start(start), .word(pend_q),
    .sck(sck), .sdat(sdat), .fin(fin)
  );

  assign start = (state_q == ST_IDLE) && pend_v_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)    state_d = ST_SHIFT;
      ST_SHIFT: if (fin)      state_d = ST_WAIT;
      ST_WAIT:  if (arm)      state_d = ST_LATCH;
      ST_LATCH: if (fall_now) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    if (load) begin
      pend_d   = com_mode ? {image[NSEG-1:1], 1'b0} : image;
      pend_v_d = 1'b1;
    end else if (start) begin
      pend_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= ST_IDLE;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      lat_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
      lat_q    <= (state_d == ST_LATCH);
      done_q   <= (state_q == ST_LATCH) && fall_now;
    end
  end

  assign lat  = lat_q;
  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
endmodule

// File: rtl/seg_refresh_chk.sv
module seg_refresh_chk #(
  parameter int FRAME_HALF = 833333
) (
  input logic clk,
  input logic rst_n,
  input logic frm,
  input logic sck,
  input logic sdat,
  input logic lat,
  input logic busy,
  input logic done
);
  logic        frm_d1_q, seen_q;
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_d1_q <= 1'b0;
      seen_q   <= 1'b0;
      run_q    <= 32'd0;
    end else begin
      frm_d1_q <= frm;
      if (frm != frm_d1_q) begin
        run_q  <= 32'd1;
        seen_q <= 1'b1;
      end else if (run_q != 32'hFFFF_FFFF) begin
        run_q  <= run_q + 32'd1;
      end
    end
  end

  p_frame_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((frm != frm_d1_q) && seen_q) |-> (run_q == 32'(FRAME_HALF)));

  p_lat_on_frame_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lat) |-> $fell(frm));

  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> $stable(sdat));

  p_no_shift_in_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lat |-> !sck);

  p_busy_covers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sck || lat) |-> busy);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(lat) && !lat && !busy));
endmodule

bind segment_refresh_seq seg_refresh_chk #(.FRAME_HALF(FRAME_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm(frm), .sck(sck), .sdat(sdat),
  .lat(lat), .busy(busy), .done(done)
);

// File: tb/segment_refresh_seq_test.sv
module segment_refresh_seq_test;
  localparam int NS = 80;
  localparam int FH = 2000;
  localparam int SH = 2;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic          com_mode = 1'b0;
  logic [NS-1:0] image = '0;
  logic          frm, sck, sdat, lat, busy, done;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  segment_refresh_seq #(.NSEG(NS), .FRAME_HALF(FH), .SCK_HALF(SH), .LATCH_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .load(load), .com_mode(com_mode), .image(image),
    .frm(frm), .sck(sck), .sdat(sdat), .lat(lat), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  // ---------------- port monitor (samples on falling clock edge) ----------
  logic          p_sck = 0, p_lat = 0, p_frm = 0, p_sdat = 0, p_busy = 0, p_done = 0;
  int            hi_run = 0, lo_run = 0, lat_run = 0, frm_run = 0, since_lat = 1000;
  int            ntog = 0, ncap = 0, last_n = 0, ndone = 0;
  logic [NS-1:0] cap = '0, last_cap = '0;
  int            e_sckw = 0, e_stab = 0, e_lat = 0, e_frm = 0, e_gap = 0, e_busy = 0, e_done = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sck && !p_sck) begin
        if (ncap > 0 && lo_run != SH) e_sckw++;
        hi_run = 1;
      end else if (sck) hi_run++;
      if (!sck && p_sck) begin
        if (hi_run != SH) e_sckw++;
        if (sdat != p_sdat) e_stab++;
        if (since_lat < SH + 1) e_gap++;
        cap = {cap[NS-2:0], sdat};
        ncap++;
        lo_run = 1;
      end else if (!sck) lo_run++;
      if (lat) begin
        if (sck) e_gap++;
        lat_run = p_lat ? lat_run + 1 : 1;
      end
      if (!lat && p_lat) begin
        if (lat_run != LW) e_lat++;
        if (!(p_frm && !frm)) e_lat++;
        since_lat = 1;
      end else if (since_lat < 1000) since_lat++;
      if (frm != p_frm) begin
        if (ntog > 0 && frm_run != FH) e_frm++;
        ntog++;
        frm_run = 1;
      end else frm_run++;
      if ((sck || lat) && !busy) e_busy++;
      if (p_busy && !busy && !(p_lat && !lat)) e_busy++;
      if (done && p_done) e_done++;
      if (done && !(p_lat && !lat)) e_done++;
      if (done) begin
        last_cap = cap;
        last_n   = ncap;
        ncap     = 0;
        ndone++;
      end
    end
    p_sck = sck; p_lat = lat; p_frm = frm; p_sdat = sdat; p_busy = busy; p_done = done;
  end

  // ---------------- helpers ------------------------------------------------
  task automatic check(input bit ok, input string req, input string act, input string exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic send(input logic [NS-1:0] img, input logic com);
    @(negedge clk);
    load = 1'b1; image = img; com_mode = com;
    @(negedge clk);
    load = 1'b0; com_mode = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int n0 = ndone;
    ok = 1'b0;
    for (int i = 0; i < 4 * FH + 1000; i++) begin
      @(negedge clk);
      if (ndone != n0) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  function automatic logic [NS-1:0] expect_img(input logic [NS-1:0] img, input logic com);
    return com ? {img[NS-1:1], 1'b0} : img;
  endfunction

  // ---------------- scenarios ----------------------------------------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    check({frm, sck, sdat, lat, busy, done} == 6'b0, "R9 outputs in reset",
          $sformatf("%b", {frm, sck, sdat, lat, busy, done}), "000000");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({frm, sck, lat, busy, done} == 5'b0, "R9 outputs after release",
          $sformatf("%b", {frm, sck, lat, busy, done}), "00000");
  endtask

  task automatic t_idle();
    int d0 = ndone;
    bit saw = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (sck || lat || busy) saw = 1'b1;
    end
    check(!saw && ncap == 0 && ndone == d0, "R10 idle without load",
          $sformatf("activity=%0d bits=%0d", saw, ncap), "activity=0 bits=0");
  endtask

  task automatic t_update(input logic [NS-1:0] img, input logic com, input string req);
    int s0 = e_sckw, st0 = e_stab, l0 = e_lat, g0 = e_gap, b0 = e_busy, d0 = e_done;
    bit ok;
    send(img, com);
    wait_done(ok);
    check(ok, "R8 update completes", $sformatf("%0d", ok), "1");
    check(last_n == NS, "R3 pulse count", $sformatf("%0d", last_n), $sformatf("%0d", NS));
    check(last_cap == expect_img(img, com), req,
          $sformatf("%h", last_cap), $sformatf("%h", expect_img(img, com)));
    check(e_sckw == s0, "R3 shift clock phase widths", $sformatf("%0d", e_sckw - s0), "0");
    check(e_stab == st0, "R4 data stable at sck fall", $sformatf("%0d", e_stab - st0), "0");
    check(e_lat == l0, "R2 latch width and frame alignment", $sformatf("%0d", e_lat - l0), "0");
    check(e_gap == g0, "R5 latch versus shift spacing", $sformatf("%0d", e_gap - g0), "0");
    check(e_busy == b0 && e_done == d0, "R8 busy and done profile",
          $sformatf("%0d/%0d", e_busy - b0, e_done - d0), "0/0");
  endtask

  task automatic t_overlap();
    logic [NS-1:0] a = 80'hA5A5_0F0F_1234_5678_9ABC;
    logic [NS-1:0] b = 80'h0123_4567_89AB_CDEF_F00D;
    int g0 = e_gap;
    bit ok;
    send(a, 1'b0);
    while (ncap < 20) @(negedge clk);
    send(b, 1'b0);
    wait_done(ok);
    check(ok && last_cap == a, "R7 current stream unchanged by load",
          $sformatf("%h", last_cap), $sformatf("%h", a));
    wait_done(ok);
    check(ok && last_cap == b, "R7 held image sent next",
          $sformatf("%h", last_cap), $sformatf("%h", b));
    check(e_gap == g0, "R5 back-to-back spacing", $sformatf("%0d", e_gap - g0), "0");
  endtask

  task automatic t_frame();
    check(ntog >= 4 && e_frm == 0, "R1 frame half periods",
          $sformatf("toggles=%0d bad=%0d", ntog, e_frm), "toggles>=4 bad=0");
  endtask

  // ---------------- watchdog -----------------------------------------------
  initial begin
    wait (cyc > 150000);
    nfail++;
    nchk++;
    $display("FAIL R8 watchdog actual=timeout expected=finished run");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  // ---------------- main ---------------------------------------------------
  initial begin
    t_reset();
    t_idle();
    t_update(80'hAAAA_AAAA_AAAA_AAAA_AAAA, 1'b0, "R4 alternating pattern order");
    t_update(80'h8000_0000_0000_0000_0000, 1'b0, "R4 highest segment first");
    t_update(80'h0000_0000_0000_0000_0001, 1'b0, "R4 segment 1 last");
    t_update({NS{1'b1}}, 1'b1, "R6 common channel forced to 0");
    t_update(80'h0000_0000_0000_0000_0003, 1'b1, "R6 segment 2 kept in common mode");
    t_overlap();
    t_frame();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule